// File: doc/BRIEF.md
# Two-Stage Gated SD Card Clock Divider

This block derives two divided clocks from a single reference and gates each one under software control. A first stage divides by a power of two to give a high-speed clock; a second stage divides that result by two or four to give the card clock. A single 10-bit control word, written through a one-register port, holds both divider codes and one stop bit per output.

The reference `clk_i` runs at twice the parent clock rate, so every output, including an undivided parent-rate clock, leaves the block straight from a flip-flop. All divided outputs come from one shared phase counter, so the two clocks always stay phase-aligned.

Stop bits take effect only while the clock they gate is low. New divider codes are applied only when the shared counter wraps, and a wrap is always a common rising edge of both outputs. Codes outside the legal set raise a sticky error flag and silence both outputs until a legal word is written.

Top module: `sdclk_divgen`

## Requirements
- R1: After reset, `rd_data_o` reads 0x300 (both stop bits set, both codes zero), `cfg_err_o` and `enabled_o` are 0, and both clock outputs stay low until a write.
- R2: Field positions in the control word are: bit 9 high-speed stop, bit 8 card stop, bits 4:2 first-stage code `pre`, bits 1:0 second-stage code `post`. `rd_data_o` returns the last written word ANDed with 0x31F, including words with illegal codes.
- R3: With legal codes and the card stop bit clear, `card_clk_o` is high for 2^(pre+post+1) and low for 2^(pre+post+1) `clk_i` cycles. Its ratio to the parent clock is therefore 2^pre times 2 (post 0) or 4 (post 1).
- R4: With `pre` 0 or 1 and the high-speed stop bit clear, `hs_clk_o` is high for 2^pre and low for 2^pre `clk_i` cycles.
- R5: While the active first-stage code is 2, 3 or 4, `hs_clk_o` stays low whatever its stop bit holds.
- R6: A set stop bit holds its own output low, and the other output keeps toggling.
- R7: A stop bit written during a high phase never shortens that phase: the output falls only at the end of its full-length high phase.
- R8: `enabled_o` is 1 exactly when both stop bits in the control word are clear.
- R9: A write with `pre` of 5 to 7 or `post` of 2 or 3 sets `cfg_err_o` from the next cycle on. Both outputs then go low once any running high phase ends, and stay low. The next legal write clears the flag.
- R10: A divider code change takes effect at the next wrap of the shared counter, so every complete high or low phase of either output has exactly the old length or exactly the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock at twice the parent clock rate |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Single-cycle write strobe for the control word |
| wr_data_i | input | 32 | Control word write data |
| rd_data_o | output | 32 | Control word readback; reserved bits read zero |
| hs_clk_o | output | 1 | Gated high-speed clock (first-stage output) |
| card_clk_o | output | 1 | Gated card clock (second-stage output) |
| enabled_o | output | 1 | Both stop bits clear |
| cfg_err_o | output | 1 | Sticky illegal-code flag |

## Verification
The assertions assume that writes arrive as isolated one-cycle strobes with no ordering constraint. They also assume that an active divider code can only be a legal one, which the block enforces itself by never loading an illegal word. The bench keeps every write strobe to a single cycle and drives it away from the active edge. It allows at least one full slow period, 300 cycles, for a new setting to settle before measuring phases. The exception is the code-change sweeps, which deliberately write while the counter runs and then classify every completed phase as old-length or new-length.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    parameter int BUS_W         = 32;
    parameter int PRE_W         = 3;
    parameter int POST_W        = 2;
    parameter int PRE_MAX       = 4;
    parameter int POST_MAX      = 1;
    parameter int HS_PRE_MAX    = 1;
    parameter int SHIFT_MAX     = PRE_MAX + POST_MAX + 1;
    parameter int CNT_W         = SHIFT_MAX + 1;
    parameter int SH_W          = $clog2(CNT_W);
    parameter int N_OUT         = 2;
    parameter int OUT_HS        = 0;
    parameter int OUT_CARD      = 1;
    parameter int BIT_STOP_HS   = 9;
    parameter int BIT_STOP_CARD = 8;
    parameter int PRE_LSB       = 2;

    typedef struct packed {
        logic              stop_hs;
        logic              stop_card;
        logic [PRE_W-1:0]  pre;
        logic [POST_W-1:0] post;
    } ctrl_t;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [POST_W-1:0] post;
    } div_cfg_t;

    function automatic ctrl_t decode_word(input logic [BUS_W-1:0] d);
        ctrl_t c;
        c.stop_hs   = d[BIT_STOP_HS];
        c.stop_card = d[BIT_STOP_CARD];
        c.pre       = d[PRE_LSB +: PRE_W];
        c.post      = d[0 +: POST_W];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] encode_word(input ctrl_t c);
        logic [BUS_W-1:0] d;
        d                    = '0;
        d[BIT_STOP_HS]       = c.stop_hs;
        d[BIT_STOP_CARD]     = c.stop_card;
        d[PRE_LSB +: PRE_W]  = c.pre;
        d[0 +: POST_W]       = c.post;
        return d;
    endfunction

    function automatic logic codes_legal(input ctrl_t c);
        return (c.pre <= PRE_W'(PRE_MAX)) && (c.post <= POST_W'(POST_MAX));
    endfunction

    // log2 of the card half-period in reference cycles
    function automatic logic [SH_W-1:0] card_shift(input div_cfg_t d);
        return SH_W'(d.pre) + SH_W'(d.post) + SH_W'(1);
    endfunction

endpackage

// File: rtl/sdclk_regs.sv
module sdclk_regs
    import sdclk_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [BUS_W-1:0] wr_data_i,
    output ctrl_t            ctrl_q,
    output logic             err_q
);

    ctrl_t ctrl_d;
    logic  unused_reserved;

    assign ctrl_d          = decode_word(wr_data_i);
    assign unused_reserved = ^{wr_data_i[BUS_W-1:BIT_STOP_HS+1],
                               wr_data_i[BIT_STOP_CARD-1:PRE_LSB+PRE_W]};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q.stop_hs   <= 1'b1;
            ctrl_q.stop_card <= 1'b1;
            ctrl_q.pre       <= '0;
            ctrl_q.post      <= '0;
            err_q            <= 1'b0;
        end else if (wr_en_i) begin
            ctrl_q <= ctrl_d;
            err_q  <= !codes_legal(ctrl_d);
        end
    end

endmodule

// File: rtl/sdclk_phase.sv
module sdclk_phase
    import sdclk_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  ctrl_t            ctrl_i,
    output div_cfg_t         act_q,
    output div_cfg_t         act_nxt,
    output logic [CNT_W-1:0] cnt_q,
    output logic [N_OUT-1:0] raw_nxt
);

    logic [SH_W-1:0]  shift;
    logic [CNT_W-1:0] wrap_val;
    logic [CNT_W-1:0] cnt_nxt;
    logic             at_wrap;
    div_cfg_t         req_cfg;

    assign shift    = card_shift(act_q);
    assign wrap_val = CNT_W'(((CNT_W+1)'(2) << shift) - (CNT_W+1)'(1));
    assign at_wrap  = (cnt_q == wrap_val);
    assign cnt_nxt  = at_wrap ? '0 : cnt_q + CNT_W'(1);

    assign req_cfg.pre  = ctrl_i.pre;
    assign req_cfg.post = ctrl_i.post;
    assign act_nxt      = (at_wrap && codes_legal(ctrl_i)) ? req_cfg : act_q;

    // Both raw clocks start high when the counter is zero
    assign raw_nxt[OUT_HS]   = ~cnt_nxt[act_q.pre];
    assign raw_nxt[OUT_CARD] = ~cnt_nxt[shift];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            act_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            act_q <= act_nxt;
        end
    end

endmodule

// File: rtl/sdclk_gate.sv
module sdclk_gate
    import sdclk_pkg::*;
#(
    parameter int N = N_OUT
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] raw_nxt_i,
    input  logic [N-1:0] want_i,
    output logic [N-1:0] clk_o
);

    for (genvar g = 0; g < N; g++) begin : g_lane
        logic raw_q;
        logic en_q;
        logic en_d;
        logic out_q;

        // Enable may change only at a raw rising edge or during a raw low phase
        assign en_d     = (raw_nxt_i[g] && raw_q) ? en_q : want_i[g];
        assign clk_o[g] = out_q;

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                raw_q <= 1'b0;
                en_q  <= 1'b0;
                out_q <= 1'b0;
            end else begin
                raw_q <= raw_nxt_i[g];
                en_q  <= en_d;
                out_q <= raw_nxt_i[g] && en_d;
            end
        end
    end

endmodule

// File: rtl/sdclk_divgen.sv
module sdclk_divgen
    import sdclk_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        wr_en_i,
    input  logic [31:0] wr_data_i,
    output logic [31:0] rd_data_o,
    output logic        hs_clk_o,
    output logic        card_clk_o,
    output logic        enabled_o,
    output logic        cfg_err_o
);

    ctrl_t            ctrl_q;
    logic             err_q;
    div_cfg_t         act_q;
    div_cfg_t         act_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [N_OUT-1:0] raw_nxt;
    logic [N_OUT-1:0] want;
    logic [N_OUT-1:0] gated;

    sdclk_regs u_regs (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .ctrl_q    (ctrl_q),
        .err_q     (err_q)
    );

    sdclk_phase u_phase (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .ctrl_i  (ctrl_q),
        .act_q   (act_q),
        .act_nxt (act_nxt),
        .cnt_q   (cnt_q),
        .raw_nxt (raw_nxt)
    );

    assign want[OUT_HS]   = !err_q && !ctrl_q.stop_hs &&
                            (act_nxt.pre <= PRE_W'(HS_PRE_MAX));
    assign want[OUT_CARD] = !err_q && !ctrl_q.stop_card;

    sdclk_gate #(.N(N_OUT)) u_gate (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .raw_nxt_i (raw_nxt),
        .want_i    (want),
        .clk_o     (gated)
    );

    assign hs_clk_o   = gated[OUT_HS];
    assign card_clk_o = gated[OUT_CARD];
    assign enabled_o  = !ctrl_q.stop_hs && !ctrl_q.stop_card;
    assign cfg_err_o  = err_q;
    assign rd_data_o  = encode_word(ctrl_q);

endmodule

// File: rtl/sdclk_divgen_chk.sv
module sdclk_divgen_chk
    import sdclk_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic             wr_en_i,
    input logic [31:0]      wr_data_i,
    input logic [31:0]      rd_data_o,
    input logic             hs_clk_o,
    input logic             card_clk_o,
    input logic             cfg_err_o,
    input logic             stop_card_i,
    input logic [PRE_W-1:0] act_pre_i,
    input logic [CNT_W-1:0] cnt_i
);

    AST_RD_ECHO: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_en_i |=> (rd_data_o == ($past(wr_data_i) & 32'h0000_031F))); // R2

    AST_HS_SLOW_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
        hs_clk_o |-> (act_pre_i <= PRE_W'(HS_PRE_MAX))); // R5

    AST_CARD_STOP_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (stop_card_i && !card_clk_o) |=> !card_clk_o); // R6

    AST_ERR_RAISE: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && ((wr_data_i[4:2] > 3'd4) || (wr_data_i[1:0] > 2'd1)))
        |=> cfg_err_o); // R9

    AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_err_o && !card_clk_o && !hs_clk_o) |=> (!card_clk_o && !hs_clk_o)); // R9

    AST_CODE_AT_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(act_pre_i) |-> (cnt_i == '0)); // R10

endmodule

bind sdclk_divgen sdclk_divgen_chk u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .rd_data_o   (rd_data_o),
    .hs_clk_o    (hs_clk_o),
    .card_clk_o  (card_clk_o),
    .cfg_err_o   (cfg_err_o),
    .stop_card_i (ctrl_q.stop_card),
    .act_pre_i   (act_q.pre),
    .cnt_i       (cnt_q)
);

// File: tb/tb_sdclk_divgen.sv
module tb_sdclk_divgen;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        hs_clk;
    logic        card_clk;
    logic        enabled;
    logic        cfg_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sdclk_divgen dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .rd_data_o  (rd_data),
        .hs_clk_o   (hs_clk),
        .card_clk_o (card_clk),
        .enabled_o  (enabled),
        .cfg_err_o  (cfg_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input int hs, input int cd, input int pre, input int post);
        return 32'((hs << 9) | (cd << 8) | (pre << 2) | post);
    endfunction

    function automatic logic sig(input int which);
        return (which == 0) ? hs_clk : card_clk;
    endfunction

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int which, output int hi, output int lo);
        logic prev;
        int   guard;
        hi = 0; lo = 0; guard = 0;
        @(negedge clk);
        prev = sig(which);
        while (guard < 1000) begin
            @(negedge clk);
            guard++;
            if (!prev && sig(which)) break;
            prev = sig(which);
        end
        hi = 1;
        while (guard < 1000) begin
            @(negedge clk);
            guard++;
            if (sig(which)) hi++; else break;
        end
        lo = 1;
        while (guard < 1000) begin
            @(negedge clk);
            guard++;
            if (!sig(which)) lo++; else break;
        end
    endtask

    task automatic count_high(input int which, input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sig(which)) highs++;
        end
    endtask

    task automatic runs(input int which, input int n, input int wr_at, input logic [31:0] d,
                        input int a, input int b, output int bad, output int na, output int nb);
        logic prev;
        int   len;
        bit   started;
        bad = 0; na = 0; nb = 0; len = 0; started = 1'b0;
        @(negedge clk);
        prev = sig(which);
        for (int i = 0; i < n; i++) begin
            if (i == wr_at) begin
                wr_en = 1'b1; wr_data = d;
            end else begin
                wr_en = 1'b0; wr_data = '0;
            end
            @(negedge clk);
            if (sig(which) != prev) begin
                if (started) begin
                    if (len == a) na++;
                    else if (len == b) nb++;
                    else bad++;
                end
                started = 1'b1;
                len = 1;
                prev = sig(which);
            end else begin
                len++;
            end
        end
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int hi, lo, h, bad, na, nb, hl, half;
        rst = 1'b1; wr_en = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(rd_data == 32'h300, "R1", "reset readback", rd_data, 32'h300);
        check(!cfg_err && !enabled, "R1", "reset flags", {cfg_err, enabled}, 0);
        count_high(1, 200, h);
        check(h == 0, "R1", "card quiet after reset", h, 0);
        count_high(0, 50, h);
        check(h == 0, "R1", "hs quiet after reset", h, 0);

        // R2 readback masking
        wr(32'hFFFF_FFFF);
        check(rd_data == 32'h31F, "R2", "all ones readback", rd_data, 32'h31F);
        check(cfg_err == 1'b1, "R9", "pre 7 flags error", cfg_err, 1);
        wr(32'h0000_02E5);
        check(rd_data == 32'h205, "R2", "reserved bits masked", rd_data, 32'h205);
        check(cfg_err == 1'b0, "R9", "legal write clears error", cfg_err, 0);

        // R3, R4, R8 sweep over every legal code pair
        for (int pre = 0; pre <= 4; pre++) begin
            for (int post = 0; post <= 1; post++) begin
                wr(cw((pre >= 2) ? 1 : 0, 0, pre, post));
                idle(300);
                half = 1 << (pre + post + 1);
                measure(1, hi, lo);
                check(hi == half, "R3", $sformatf("card high pre=%0d post=%0d", pre, post), hi, half);
                check(lo == half, "R3", $sformatf("card low pre=%0d post=%0d", pre, post), lo, half);
                check(enabled == (pre < 2), "R8", "enabled flag", enabled, (pre < 2));
                if (pre < 2) begin
                    measure(0, hi, lo);
                    check(hi == (1 << pre), "R4", $sformatf("hs high pre=%0d", pre), hi, 1 << pre);
                    check(lo == (1 << pre), "R4", $sformatf("hs low pre=%0d", pre), lo, 1 << pre);
                end
            end
        end

        // R5 slow pre-divide forces hs off even with stop clear
        wr(cw(0, 0, 2, 0));
        idle(300);
        count_high(0, 300, h);
        check(h == 0, "R5", "hs low at pre=2", h, 0);
        measure(1, hi, lo);
        check(hi == 8 && lo == 8, "R5", "card still runs at pre=2", hi, 8);
        check(enabled == 1'b1, "R8", "both stops clear", enabled, 1);

        // R6 card stopped, hs running
        wr(cw(0, 1, 0, 0));
        idle(300);
        count_high(1, 300, h);
        check(h == 0, "R6", "card stopped", h, 0);
        measure(0, hi, lo);
        check(hi == 1 && lo == 1, "R6", "hs keeps running", hi, 1);
        check(enabled == 1'b0, "R8", "one stop set", enabled, 0);

        // R7 stop written mid-high keeps full high phase
        wr(cw(1, 0, 4, 1));
        idle(300);
        begin
            logic prev;
            int   g;
            g = 0;
            @(negedge clk);
            prev = card_clk;
            while (g < 1000) begin
                @(negedge clk);
                g++;
                if (!prev && card_clk) break;
                prev = card_clk;
            end
            hl = 1;
            repeat (5) begin
                @(negedge clk);
                if (card_clk) hl++;
            end
            wr_en = 1'b1; wr_data = cw(1, 1, 4, 1);
            while (g < 2000) begin
                @(negedge clk);
                g++;
                wr_en = 1'b0; wr_data = '0;
                if (card_clk) hl++; else break;
            end
        end
        check(hl == 64, "R7", "high phase not shortened by stop", hl, 64);
        count_high(1, 300, h);
        check(h == 0, "R6", "card stays stopped", h, 0);

        // R9 illegal first-stage code
        wr(cw(0, 0, 0, 0));
        idle(300);
        wr(cw(0, 0, 5, 0));
        check(cfg_err == 1'b1, "R9", "pre 5 flags error", cfg_err, 1);
        check(rd_data == cw(0, 0, 5, 0), "R2", "illegal word readback", rd_data, cw(0, 0, 5, 0));
        idle(200);
        count_high(1, 300, h);
        check(h == 0, "R9", "card silent on error", h, 0);
        count_high(0, 100, h);
        check(h == 0, "R9", "hs silent on error", h, 0);
        wr(cw(0, 0, 0, 1));
        check(cfg_err == 1'b0, "R9", "error cleared", cfg_err, 0);
        idle(300);
        measure(1, hi, lo);
        check(hi == 4 && lo == 4, "R9", "card resumes after clear", hi, 4);
        // R9 illegal second-stage code
        wr(cw(0, 0, 1, 2));
        check(cfg_err == 1'b1, "R9", "post 2 flags error", cfg_err, 1);
        idle(200);
        count_high(1, 300, h);
        check(h == 0, "R9", "card silent on post error", h, 0);
        wr(cw(0, 0, 1, 1));
        check(cfg_err == 1'b0, "R9", "error cleared again", cfg_err, 0);

        // R10 code changes land on whole phases
        wr(cw(0, 0, 0, 0));
        idle(300);
        runs(1, 800, 20, cw(1, 0, 4, 1), 2, 64, bad, na, nb);
        check(bad == 0, "R10", "card runs fast to slow", bad, 0);
        check(na > 0 && nb > 0, "R10", "both lengths seen fast to slow", na * nb, 1);
        runs(1, 800, 20, cw(0, 0, 1, 1), 64, 8, bad, na, nb);
        check(bad == 0, "R10", "card runs slow to fast", bad, 0);
        check(na > 0 && nb > 0, "R10", "both lengths seen slow to fast", na * nb, 1);
        idle(300);
        runs(0, 300, 20, cw(0, 0, 0, 0), 2, 1, bad, na, nb);
        check(bad == 0, "R10", "hs runs on code change", bad, 0);
        check(na > 0 && nb > 0, "R10", "both hs lengths seen", na * nb, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule